// File: doc/BRIEF.md
# Flash Vector Page Remap Unit

This block is the address-translation front end of an on-chip flash controller. Every CPU address passes through it on its way to the flash array. When the boot mode allows remapping, CPU addresses that fall inside the lowest 512-byte page are redirected to a programmable flash page called the vector map. All other addresses pass through unchanged. The translated address is then classified into the loader region, the application region or the data region. Each of these regions has its own select flag.

Software moves the vector page in two steps. First it writes a target address into the target register. Then it triggers the remap command code. An aligned target is staged for one busy cycle and then committed. A misaligned target raises a fail flag and leaves the mapping unchanged.

The boundary between the application region and the data region is loaded from a configuration word by an initialisation pulse. Until that pulse arrives, all of main flash counts as application region. In the two fixed boot modes, a different mapping applies:
- Loader-only boot places the loader page at address 0.
- Application-only boot hides the loader page.

Top module: `vpr_unit`

## Requirements
- R1: After reset the vector map is 0, status is 0, addresses pass through unchanged, and every main-flash address below 0x8000 is flagged application until the first init load pulse.
- R2: In the remap boot modes (boot_mode 2'b10 application+remap, 2'b11 loader+remap), a CPU address below 0x200 translates to {vector map, address[8:0]}. Any address at or above 0x200 passes through unchanged.
- R3: Writing the target register on its own leaves the mapping and status unchanged.
- R4: The remap command is code 0x2E, and it acts on the target register value held when it is triggered.
  - In the cycle after the trigger, status bit 0 (busy) is 1 and translation still uses the old map.
  - From the cycle after that, the new map applies, busy is 0, and status bits [23:9] show the map.
- R5: A remap command whose target has any of bits [8:0] set does not raise busy. It sets status bit 1 (fail) from the next cycle and leaves the map unchanged. A later accepted command clears fail.
- R6: A trigger that carries any other code, or that arrives while busy is 1, has no effect.
- R7: In boot modes 2'b00 and 2'b01 remap commands are ignored: the map stays 0 and busy and fail stay 0.
- R8: In loader-only boot (2'b01), a CPU address below 0x200 translates to 0x10_0000 + address[8:0] and is flagged loader. Any other address passes through with no region flag, so the application region cannot be reached.
- R9: In application-only boot (2'b00), every address passes through and the loader flag is never raised.
- R10: After an init load of base B, a translated address in [B, 0x8000) is flagged data and one below B is flagged application. An address at or above 0x8000 that is not in the loader page carries no main-flash flag. At most one flag is ever set.
- R11: In the remap modes, a translated address within [0x10_0000, 0x10_0200) is flagged loader.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 2 | 00 application-only, 01 loader-only, 10 application+remap, 11 loader+remap |
| cpu_addr | input | 24 | CPU byte address |
| flash_addr | output | 24 | Translated flash byte address |
| sel_app | output | 1 | Translated address lies in the application region |
| sel_data | output | 1 | Translated address lies in the data region |
| sel_ldr | output | 1 | Translated address lies in the loader page |
| tgt_wr | input | 1 | Write strobe for the target register |
| tgt_wdata | input | 24 | Target address to write |
| cmd_go | input | 1 | Command trigger |
| cmd_code | input | 8 | Command code sampled with cmd_go |
| cfg_load | input | 1 | Init pulse that loads the data base |
| cfg_word | input | 24 | Configuration word holding the data base |
| status | output | 24 | [23:9] vector map, [1] fail, [0] busy, other bits 0 |

## Verification
The assertions assume that boot_mode only changes while reset is asserted. They also assume that cpu_addr is stable for the sampled cycle. The bench changes boot_mode only inside its reset task and drives every input on the falling clock edge. The assertions also take the command inputs to be plain levels sampled at the clock. For this reason the bench holds cmd_go for one cycle, except in the one case where it holds it through the busy cycle to test that a second trigger is ignored.

// File: rtl/vpr_pkg.sv
`timescale 1ns/1ps
package vpr_pkg;
  typedef enum logic [1:0] {
    BOOT_APP_ONLY  = 2'b00,
    BOOT_LDR_ONLY  = 2'b01,
    BOOT_APP_REMAP = 2'b10,
    BOOT_LDR_REMAP = 2'b11
  } boot_e;

  typedef struct packed {
    logic app;
    logic data;
    logic ldr;
  } region_t;

  localparam logic [7:0] CMD_VEC_REMAP = 8'h2E;

  function automatic logic boot_can_remap(input boot_e b);
    return (b == BOOT_APP_REMAP) || (b == BOOT_LDR_REMAP);
  endfunction
endpackage

// File: rtl/vpr_cmd.sv
`timescale 1ns/1ps
module vpr_cmd
  import vpr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 9,
  parameter int CODE_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          remap_en,
  input  logic                          tgt_wr,
  input  logic [ADDR_W-1:0]             tgt_wdata,
  input  logic                          cmd_go,
  input  logic [CODE_W-1:0]             cmd_code,
  output logic [ADDR_W-PAGE_BITS-1:0]   vmap,
  output logic [ADDR_W-PAGE_BITS-1:0]   pend_vmap,
  output logic                          busy,
  output logic                          fail,
  output logic                          cmd_accept,
  output logic                          cmd_reject
);
  localparam int VMAP_W = ADDR_W - PAGE_BITS;

  function automatic logic page_aligned(input logic [ADDR_W-1:0] a);
    return a[PAGE_BITS-1:0] == '0;
  endfunction

  logic [ADDR_W-1:0] tgt_q;
  logic [VMAP_W-1:0] vmap_q, pend_q;
  logic              busy_q, fail_q;
  logic              cmd_hit;

  assign cmd_hit    = cmd_go && remap_en && !busy_q &&
                      (cmd_code == CODE_W'(CMD_VEC_REMAP));
  assign cmd_accept = cmd_hit && page_aligned(tgt_q);
  assign cmd_reject = cmd_hit && !page_aligned(tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      pend_q <= '0;
      vmap_q <= '0;
      busy_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (tgt_wr) tgt_q <= tgt_wdata;
      if (cmd_accept) begin
        pend_q <= tgt_q[ADDR_W-1:PAGE_BITS];
        busy_q <= 1'b1;
        fail_q <= 1'b0;
      end else if (cmd_reject) begin
        fail_q <= 1'b1;
      end
      if (busy_q) begin
        vmap_q <= pend_q;
        busy_q <= 1'b0;
      end
    end
  end

  assign vmap      = vmap_q;
  assign pend_vmap = pend_q;
  assign busy      = busy_q;
  assign fail      = fail_q;
endmodule

// File: rtl/vpr_xlate.sv
`timescale 1ns/1ps
module vpr_xlate
  import vpr_pkg::*;
#(
  parameter int                 ADDR_W    = 24,
  parameter int                 PAGE_BITS = 9,
  parameter logic [ADDR_W-1:0]  LDR_BASE  = 24'h10_0000
) (
  input  boot_e                         boot,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [ADDR_W-PAGE_BITS-1:0]   vmap,
  output logic [ADDR_W-1:0]             flash_addr,
  output logic                          in_window
);
  localparam int VMAP_W = ADDR_W - PAGE_BITS;

  function automatic logic [ADDR_W-1:0] page_redirect(
    input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] a);
    return {base[ADDR_W-1:PAGE_BITS], a[PAGE_BITS-1:0]};
  endfunction

  assign in_window = (cpu_addr[ADDR_W-1:PAGE_BITS] == '0);

  always_comb begin
    flash_addr = cpu_addr;
    unique case (boot)
      BOOT_LDR_ONLY:
        if (in_window) flash_addr = page_redirect(LDR_BASE, cpu_addr);
      BOOT_APP_REMAP, BOOT_LDR_REMAP:
        if (in_window) flash_addr = page_redirect({vmap, {PAGE_BITS{1'b0}}}, cpu_addr);
      default: flash_addr = cpu_addr;
    endcase
  end
endmodule

// File: rtl/vpr_region.sv
`timescale 1ns/1ps
module vpr_region
  import vpr_pkg::*;
#(
  parameter int                 ADDR_W   = 24,
  parameter logic [ADDR_W-1:0]  LDR_BASE = 24'h10_0000,
  parameter int                 LDR_SIZE = 512,
  parameter int                 MAIN_TOP = 32'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  boot_e              boot,
  input  logic               in_window,
  input  logic [ADDR_W-1:0]  flash_addr,
  input  logic               cfg_load,
  input  logic [ADDR_W-1:0]  cfg_word,
  output region_t            sel,
  output logic               dbase_valid
);
  localparam logic [ADDR_W:0] LDR_LO   = {1'b0, LDR_BASE};
  localparam logic [ADDR_W:0] LDR_HI   = LDR_LO + (ADDR_W+1)'(LDR_SIZE);
  localparam logic [ADDR_W:0] MAIN_END = (ADDR_W+1)'(MAIN_TOP);

  logic [ADDR_W-1:0] dbase_q;
  logic              dval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbase_q <= '0;
      dval_q  <= 1'b0;
    end else if (cfg_load) begin
      dbase_q <= cfg_word;
      dval_q  <= 1'b1;
    end
  end

  function automatic region_t classify(input logic [ADDR_W-1:0] a,
                                       input logic dv,
                                       input logic [ADDR_W-1:0] db);
    region_t r;
    logic    main_hit;
    main_hit = {1'b0, a} < MAIN_END;
    r.ldr    = ({1'b0, a} >= LDR_LO) && ({1'b0, a} < LDR_HI);
    r.data   = main_hit && dv && (a >= db);
    r.app    = main_hit && !r.data;
    return r;
  endfunction

  region_t raw;
  assign raw = classify(flash_addr, dval_q, dbase_q);

  always_comb begin
    sel = raw;
    unique case (boot)
      BOOT_APP_ONLY: sel.ldr = 1'b0;
      BOOT_LDR_ONLY: sel = in_window ? region_t'{app: 1'b0, data: 1'b0, ldr: 1'b1}
                                     : region_t'('0);
      default:       sel = raw;
    endcase
  end

  assign dbase_valid = dval_q;
endmodule

// File: rtl/vpr_unit.sv
`timescale 1ns/1ps
module vpr_unit
  import vpr_pkg::*;
#(
  parameter int                 ADDR_W    = 24,
  parameter int                 PAGE_BITS = 9,
  parameter int                 CODE_W    = 8,
  parameter logic [ADDR_W-1:0]  LDR_BASE  = 24'h10_0000,
  parameter int                 LDR_SIZE  = 512,
  parameter int                 MAIN_TOP  = 32'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         boot_mode,
  input  logic [ADDR_W-1:0]  cpu_addr,
  output logic [ADDR_W-1:0]  flash_addr,
  output logic               sel_app,
  output logic               sel_data,
  output logic               sel_ldr,
  input  logic               tgt_wr,
  input  logic [ADDR_W-1:0]  tgt_wdata,
  input  logic               cmd_go,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic               cfg_load,
  input  logic [ADDR_W-1:0]  cfg_word,
  output logic [ADDR_W-1:0]  status
);
  localparam int VMAP_W = ADDR_W - PAGE_BITS;

  boot_e             boot;
  logic              remap_en;
  logic [VMAP_W-1:0] vmap, pend_vmap;
  logic              busy, fail, cmd_accept, cmd_reject;
  logic              in_window, dbase_valid;
  region_t           sel;

  assign boot     = boot_e'(boot_mode);
  assign remap_en = boot_can_remap(boot);

  vpr_cmd #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .CODE_W(CODE_W)) cmd_i (
    .clk(clk), .rst_n(rst_n), .remap_en(remap_en),
    .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata),
    .cmd_go(cmd_go), .cmd_code(cmd_code),
    .vmap(vmap), .pend_vmap(pend_vmap), .busy(busy), .fail(fail),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  vpr_xlate #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LDR_BASE(LDR_BASE)) xlate_i (
    .boot(boot), .cpu_addr(cpu_addr), .vmap(vmap),
    .flash_addr(flash_addr), .in_window(in_window)
  );

  vpr_region #(.ADDR_W(ADDR_W), .LDR_BASE(LDR_BASE), .LDR_SIZE(LDR_SIZE),
               .MAIN_TOP(MAIN_TOP)) region_i (
    .clk(clk), .rst_n(rst_n), .boot(boot), .in_window(in_window),
    .flash_addr(flash_addr), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .sel(sel), .dbase_valid(dbase_valid)
  );

  assign sel_app  = sel.app;
  assign sel_data = sel.data;
  assign sel_ldr  = sel.ldr;
  assign status   = {vmap, {(PAGE_BITS-2){1'b0}}, fail, busy};
endmodule

// File: rtl/vpr_unit_chk.sv
`timescale 1ns/1ps
module vpr_unit_chk #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        remap_en,
  input logic [ADDR_W-1:0]           cpu_addr,
  input logic [ADDR_W-1:0]           flash_addr,
  input logic [ADDR_W-PAGE_BITS-1:0] vmap,
  input logic [ADDR_W-PAGE_BITS-1:0] pend_vmap,
  input logic                        busy,
  input logic                        fail,
  input logic                        sel_app,
  input logic                        sel_data,
  input logic                        sel_ldr,
  input logic                        dbase_valid
);
  logic low_page;
  assign low_page = (cpu_addr[ADDR_W-1:PAGE_BITS] == '0);

  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    remap_en && low_page |-> flash_addr == {vmap, cpu_addr[PAGE_BITS-1:0]});

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    remap_en && !low_page |-> flash_addr == cpu_addr);

  p_vmap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(vmap));

  p_busy_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> vmap == $past(pend_vmap));

  p_fail_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail && busy));

  p_fixed_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_en |-> vmap == '0 && !busy && !fail);

  p_one_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_app, sel_data, sel_ldr}));

  p_no_data_pre_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dbase_valid |-> !sel_data);
endmodule

bind vpr_unit vpr_unit_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .remap_en(remap_en), .cpu_addr(cpu_addr),
  .flash_addr(flash_addr), .vmap(vmap), .pend_vmap(pend_vmap),
  .busy(busy), .fail(fail), .sel_app(sel_app), .sel_data(sel_data),
  .sel_ldr(sel_ldr), .dbase_valid(dbase_valid)
);

// File: tb/vpr_unit_tb_top.sv
`timescale 1ns/1ps
module vpr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  boot_mode = 2'b10;
  logic [23:0] cpu_addr = '0;
  logic [23:0] flash_addr;
  logic        sel_app, sel_data, sel_ldr;
  logic        tgt_wr = 1'b0;
  logic [23:0] tgt_wdata = '0;
  logic        cmd_go = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic        cfg_load = 1'b0;
  logic [23:0] cfg_word = '0;
  logic [23:0] status;

  always #2.5 clk = ~clk;

  vpr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cpu_addr(cpu_addr),
    .flash_addr(flash_addr), .sel_app(sel_app), .sel_data(sel_data),
    .sel_ldr(sel_ldr), .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata),
    .cmd_go(cmd_go), .cmd_code(cmd_code), .cfg_load(cfg_load),
    .cfg_word(cfg_word), .status(status)
  );

  typedef struct {
    logic [23:0] fa;
    logic [2:0]  flags;
    logic [23:0] st;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  // reference model state
  logic [1:0]  m_boot;
  logic [14:0] m_vmap, m_pend;
  logic [23:0] m_tgt, m_dbase;
  logic        m_busy, m_fail, m_dval;

  function automatic exp_t predict(input logic [23:0] a, input string tag);
    exp_t e;
    logic low, main, dat, ldr;
    low = a < 24'h200;
    if (m_boot == 2'b01 && low)      e.fa = 24'h10_0000 + a;
    else if (m_boot[1] && low)       e.fa = {m_vmap, 9'h0} + a;
    else                             e.fa = a;
    ldr  = e.fa >= 24'h10_0000 && e.fa < 24'h10_0200;
    main = e.fa < 24'h8000;
    dat  = main && m_dval && e.fa >= m_dbase;
    if (m_boot == 2'b00) ldr = 1'b0;
    if (m_boot == 2'b01) e.flags = low ? 3'b001 : 3'b000;
    else                 e.flags = {main && !dat, dat, ldr};
    e.st  = ({9'h0, m_vmap} << 9) | {22'h0, m_fail, m_busy};
    e.tag = tag;
    return e;
  endfunction

  // monitor: compares design outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (flash_addr !== e.fa || {sel_app, sel_data, sel_ldr} !== e.flags ||
            status !== e.st) begin
          n_errors++;
          $display("FAIL %s: got addr=%h flags=%b status=%h, expected addr=%h flags=%b status=%h",
                   e.tag, flash_addr, {sel_app, sel_data, sel_ldr}, status,
                   e.fa, e.flags, e.st);
        end
      end
    end
  end

  task automatic probe(input logic [23:0] a, input string tag);
    cpu_addr = a;
    exp_q.push_back(predict(a, tag));
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_n = 1'b0;
    boot_mode = mode;
    m_boot = mode; m_vmap = '0; m_pend = '0; m_tgt = '0; m_dbase = '0;
    m_busy = 1'b0; m_fail = 1'b0; m_dval = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_tgt(input logic [23:0] a);
    tgt_wr = 1'b1; tgt_wdata = a;
    @(negedge clk);
    tgt_wr = 1'b0;
    m_tgt = a;
  endtask

  task automatic load_cfg(input logic [23:0] w);
    cfg_load = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_load = 1'b0;
    m_dval = 1'b1; m_dbase = w;
  endtask

  // trigger, probe in the cycle after, then apply the modelled commit
  task automatic cmd(input logic [7:0] code, input logic [23:0] pa, input string tag);
    logic hit;
    cmd_go = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_go = 1'b0;
    hit = m_boot[1] && code == 8'h2E && !m_busy;
    if (hit && m_tgt[8:0] == 9'h0) begin
      m_busy = 1'b1; m_fail = 1'b0; m_pend = m_tgt[23:9];
    end else if (hit) begin
      m_fail = 1'b1;
    end
    probe(pa, tag);
    if (m_busy) begin m_vmap = m_pend; m_busy = 1'b0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    do_reset(2'b10);
    probe(24'h40,   "R1 reset passthrough");
    probe(24'h7F00, "R1 whole main flash is app before init");
    load_cfg(24'h6000);
    probe(24'h6000, "R10 data at base");
    probe(24'h5FFC, "R10 app below base");
    probe(24'h7FFF, "R10 data at top");
    probe(24'h8000, "R10 above main flash");
    probe(24'h200,  "R2 first address outside window");
    wr_tgt(24'h10_0000);
    probe(24'h4,    "R3 target write alone");
    cmd(8'h2D, 24'h4, "R6 other code ignored");
    probe(24'h4,    "R6 map unchanged after other code");
    cmd(8'h2E, 24'h4, "R4 busy cycle keeps old map");
    probe(24'h4,    "R4 R11 new map to loader page");
    probe(24'h1FF,  "R11 last window byte");
    wr_tgt(24'h210);
    cmd(8'h2E, 24'h10, "R5 misaligned target no busy");
    probe(24'h10,   "R5 fail held map unchanged");
    wr_tgt(24'h400);
    cmd(8'h2E, 24'h1FF, "R5 accepted command clears fail");
    probe(24'h1FF,  "R2 remapped to application page");
    // second trigger held through the busy cycle must be ignored
    wr_tgt(24'h600);
    cmd_go = 1'b1; cmd_code = 8'h2E;
    @(negedge clk);
    tgt_wr = 1'b1; tgt_wdata = 24'h800;
    m_busy = 1'b1; m_pend = 15'h3; m_fail = 1'b0;
    probe(24'h8, "R6 trigger during busy");
    cmd_go = 1'b0; tgt_wr = 1'b0;
    m_busy = 1'b0; m_vmap = 15'h3; m_tgt = 24'h800;
    probe(24'h8, "R6 busy retrigger ignored");
    probe(24'h8, "R6 no late second commit");

    do_reset(2'b00);
    wr_tgt(24'h10_0000);
    cmd(8'h2E, 24'h8, "R7 command ignored app-only");
    probe(24'h8,      "R7 map stays zero");
    probe(24'h10_0000, "R9 loader hidden");

    do_reset(2'b01);
    probe(24'h20,  "R8 loader at zero");
    probe(24'h300, "R8 application unreachable");
    wr_tgt(24'h400);
    cmd(8'h2E, 24'h20, "R7 command ignored loader-only");
    probe(24'h20,  "R7 R8 loader still at zero");

    do_reset(2'b11);
    probe(24'h20, "R1 R2 loader+remap default map");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule